// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Unit

This block decides when a small processor core accepts an interrupt. Two five-bit registers sit on a simple byte bus: an enable mask and a request-flag register. Peripherals raise a flag bit with a single-cycle pulse. The unit also tracks a three-state master enable: off, armed, or on. The core moves it with disable, enable and return-from-interrupt strobes.

The core raises `boundary` for one cycle between instructions. At that moment the unit looks at the enabled, flagged sources. If the master enable is on and at least one source is pending, the unit takes the lowest-numbered one. It then clears that flag bit and turns the master enable off. In the next cycle it presents the handler address together with the two stack writes that save the return PC. The core's push sequencer performs those writes.

Top module: `irq_dispatch`

## Requirements
- R1: The enable register reads at 0xFFFF and the flag register at 0xFF0F. Each holds 5 bits in positions 4..0, and bits 7..5 read as 1. Any other address reads 0xFF, and a write to any other address changes neither register.
- R2: A pulse on `irq_req[n]` sets flag bit n. When a bus write to the flag register lands in the same cycle, the pulsed bit still ends up set.
- R3: The pending set is enable AND flag. The lowest pending bit n wins, and its handler address is 0x0040 + 8*n (bit 0 gives 0x40 and bit 4 gives 0x60).
- R4: A dispatch can only start on a cycle where `boundary` is high, the master enable is on and the pending set is non-empty. `dispatch` then pulses high for one cycle in the next cycle. With no pending bit, nothing is dispatched.
- R5: A dispatch turns the master enable off and clears only the serviced flag bit, so a following boundary does not dispatch again.
- R6: The enable strobe moves an off master enable to armed. The first boundary seen while armed moves it to on without dispatching, so the earliest dispatch comes at the boundary after that.
- R7: The disable strobe turns the master enable off at once and blocks a dispatch on the same cycle. The return strobe turns it on at once. Priority is disable, then dispatch, then return, then enable.
- R8: With each dispatch the unit outputs two stack writes. PC[15:8] goes to SP-1 and PC[7:0] goes to SP-2, using the `pc` and `sp` values sampled on the boundary cycle.
- R9: After reset both registers are 0, the master enable is off and `dispatch` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte bus address |
| bus_wr | input | 1 | Byte bus write strobe |
| bus_wdata | input | 8 | Byte bus write data |
| bus_rdata | output | 8 | Byte bus read data (combinational) |
| irq_req | input | 5 | Peripheral request pulses |
| di_strobe | input | 1 | Disable master enable |
| ei_strobe | input | 1 | Arm master enable |
| reti_strobe | input | 1 | Enable master enable at once |
| boundary | input | 1 | Instruction boundary |
| pc | input | 16 | Return PC |
| sp | input | 16 | Current stack pointer |
| dispatch | output | 1 | Dispatch pulse |
| vector | output | 16 | Handler address |
| push_hi_addr | output | 16 | Address for the high PC byte |
| push_hi_data | output | 8 | High PC byte |
| push_lo_addr | output | 16 | Address for the low PC byte |
| push_lo_data | output | 8 | Low PC byte |

## Verification
A master enable stuck in the wrong state shows up at the very next boundary with pending work. Either a dispatch appears that should not, or an expected one is missing. The armed-state sequence is therefore exercised one boundary at a time. A flag bit that was wrongly cleared or kept shows up on the next flag-register read, or as a repeated vector at a later boundary. A bad priority encoding gives a wrong vector on the first cycle of `dispatch`, and the scoreboard compares every dispatch, including its push fields, against a queue of expected items.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int          NSRC      = 5,
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [15:0] IE_ADDR   = 16'hFFFF,
  parameter logic [15:0] IF_ADDR   = 16'hFF0F,
  parameter logic [15:0] VEC_BASE  = 16'h0040,
  parameter int          VEC_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NSRC-1:0] irq_req,
  input  logic          di_strobe,
  input  logic          ei_strobe,
  input  logic          reti_strobe,
  input  logic          boundary,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] sp,
  output logic          dispatch,
  output logic [AW-1:0] vector,
  output logic [AW-1:0] push_hi_addr,
  output logic [DW-1:0] push_hi_data,
  output logic [AW-1:0] push_lo_addr,
  output logic [DW-1:0] push_lo_data
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [1:0] ME_OFF = 2'd0, ME_ARM = 2'd1, ME_ON = 2'd2;

  logic [NSRC-1:0] ie_q, if_q, pend, grant, if_base;
  logic [IW-1:0]   win;
  logic [1:0]      me_q, me_d;
  logic            fire, wr_ie, wr_if;

  assign pend  = ie_q & if_q;
  assign fire  = boundary & (me_q == ME_ON) & (|pend) & ~di_strobe;
  assign grant = fire ? (NSRC'(1) << win) : '0;
  assign wr_ie = bus_wr & (bus_addr == IE_ADDR);
  assign wr_if = bus_wr & (bus_addr == IF_ADDR);
  assign if_base = wr_if ? bus_wdata[NSRC-1:0] : if_q;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) win = IW'(i);
  end

  always_comb begin
    bus_rdata = '1;
    if (bus_addr == IE_ADDR)      bus_rdata[NSRC-1:0] = ie_q;
    else if (bus_addr == IF_ADDR) bus_rdata[NSRC-1:0] = if_q;
  end

  always_comb begin
    me_d = me_q;
    if (di_strobe)                         me_d = ME_OFF;
    else if (fire)                         me_d = ME_OFF;
    else if (reti_strobe)                  me_d = ME_ON;
    else if (ei_strobe)                    me_d = (me_q == ME_ON) ? ME_ON : ME_ARM;
    else if (boundary && me_q == ME_ARM)   me_d = ME_ON;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q         <= '0;
      if_q         <= '0;
      me_q         <= ME_OFF;
      dispatch     <= 1'b0;
      vector       <= '0;
      push_hi_addr <= '0;
      push_hi_data <= '0;
      push_lo_addr <= '0;
      push_lo_data <= '0;
    end else begin
      if (wr_ie) ie_q <= bus_wdata[NSRC-1:0];
      if_q     <= (if_base & ~grant) | irq_req;
      me_q     <= me_d;
      dispatch <= fire;
      if (fire) begin
        vector       <= VEC_BASE + (AW'(win) << VEC_SHIFT);
        push_hi_addr <= sp - AW'(1);
        push_hi_data <= pc[2*DW-1:DW];
        push_lo_addr <= sp - AW'(2);
        push_lo_data <= pc[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        di_strobe,
  input logic        ei_strobe,
  input logic        reti_strobe,
  input logic        dispatch,
  input logic [15:0] vector,
  input logic [15:0] push_hi_addr,
  input logic [15:0] push_lo_addr,
  input logic [1:0]  me_q
);
  AST_DISP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) !boundary |=> !dispatch); // R4
  AST_DISP_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n) dispatch |-> $past(me_q) == 2'd2); // R4
  AST_DISP_TURNS_OFF: assert property (@(posedge clk) disable iff (!rst_n) dispatch |-> me_q == 2'd0); // R5
  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> (vector[2:0] == 3'd0 && vector >= 16'h0040 && vector <= 16'h0060)); // R3
  AST_ARM_TO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && me_q == 2'd1 && !di_strobe && !ei_strobe && !reti_strobe) |=> me_q == 2'd2); // R6
  AST_DI_OFF: assert property (@(posedge clk) disable iff (!rst_n) di_strobe |=> me_q == 2'd0); // R7
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> push_lo_addr == push_hi_addr - 16'd1); // R8
endmodule

bind irq_dispatch irq_dispatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .di_strobe(di_strobe),
  .ei_strobe(ei_strobe), .reti_strobe(reti_strobe), .dispatch(dispatch),
  .vector(vector), .push_hi_addr(push_hi_addr), .push_lo_addr(push_lo_addr),
  .me_q(me_q)
);

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;
  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 0, pc = 16'h1234, sp = 16'hFFFE;
  logic bus_wr = 0, di_strobe = 0, ei_strobe = 0, reti_strobe = 0, boundary = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [4:0] irq_req = 0;
  logic dispatch;
  logic [15:0] vector, push_hi_addr, push_lo_addr;
  logic [7:0] push_hi_data, push_lo_data;
  int checks = 0, errors = 0;

  typedef struct packed { logic [15:0] vec, ha; logic [7:0] hd; logic [15:0] la; logic [7:0] ld; } item_t;
  item_t expq[$];

  always #10 clk = ~clk;

  irq_dispatch u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  always @(negedge clk) if (rst_n && dispatch) begin
    item_t e;
    checks++;
    if (expq.size() == 0) begin
      errors++; $display("FAIL R4 actual=dispatch vector %0h expected=no dispatch", vector);
    end else begin
      e = expq.pop_front();
      if ({vector, push_hi_addr, push_hi_data, push_lo_addr, push_lo_data} !== e) begin
        errors++;
        $display("FAIL R3/R8 actual=%0h %0h %0h %0h %0h expected=%0h %0h %0h %0h %0h", vector,
                 push_hi_addr, push_hi_data, push_lo_addr, push_lo_data, e.vec, e.ha, e.hd, e.la, e.ld);
      end
    end
  end

  task automatic expect_disp(input int bitn);
    item_t e;
    e.vec = 16'h0040 + 16'(bitn * 8);
    e.ha = sp - 16'd1; e.hd = pc[15:8]; e.la = sp - 16'd2; e.ld = pc[7:0];
    expq.push_back(e);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
    bus_addr = a; #1; chk(req, bus_rdata, exp);
  endtask
  task automatic bnd();
    boundary = 1; @(negedge clk); boundary = 0; @(negedge clk);
  endtask
  task automatic strobe_di();   di_strobe = 1;   @(negedge clk); di_strobe = 0;   endtask
  task automatic strobe_ei();   ei_strobe = 1;   @(negedge clk); ei_strobe = 0;   endtask
  task automatic strobe_reti(); reti_strobe = 1; @(negedge clk); reti_strobe = 0; endtask
  task automatic drained(input string req);
    chk(req, expq.size(), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++; $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R9 dispatch low", dispatch, 0);
    rd("R9 R1 IE reset", 16'hFFFF, 8'hE0);
    rd("R9 R1 IF reset", 16'hFF0F, 8'hE0);
    rd("R1 unmapped", 16'h1234, 8'hFF);
    wr(16'hFFFF, 8'h1F); rd("R1 IE write", 16'hFFFF, 8'hFF);
    wr(16'hFF0F, 8'h0A); rd("R1 IF write", 16'hFF0F, 8'hEA);
    bnd(); drained("R4 off no dispatch"); rd("R4 flags kept", 16'hFF0F, 8'hEA);
    strobe_ei(); bnd(); drained("R6 armed no dispatch");
    expect_disp(1); bnd(); drained("R6 R3 dispatch bit1");
    rd("R5 serviced bit cleared", 16'hFF0F, 8'hE8);
    bnd(); drained("R5 off after dispatch");
    pc = 16'hBEEF; sp = 16'hC010;
    strobe_reti(); expect_disp(3); bnd(); drained("R7 R8 reti dispatch bit3");
    rd("R5 flags empty", 16'hFF0F, 8'hE0);
    wr(16'hFFFF, 8'h10); wr(16'hFF0F, 8'h0F);
    strobe_reti(); bnd(); drained("R4 no pending");
    rd("R4 flags untouched", 16'hFF0F, 8'hEF);
    wr(16'hFF0F, 8'h10); expect_disp(4); bnd(); drained("R3 bit4 vector 60");
    bus_addr = 16'hFF0F; bus_wdata = 8'h00; bus_wr = 1; irq_req = 5'b00100;
    @(negedge clk); bus_wr = 0; irq_req = 0;
    rd("R2 set wins", 16'hFF0F, 8'hE4);
    irq_req = 5'b00001; @(negedge clk); irq_req = 0;
    rd("R2 pulse sets", 16'hFF0F, 8'hE5);
    wr(16'hFF10, 8'h00); rd("R1 other write IF", 16'hFF0F, 8'hE5);
    rd("R1 other write IE", 16'hFFFF, 8'hF0);
    wr(16'hFFFF, 8'h1F);
    strobe_reti(); strobe_di(); bnd(); drained("R7 di blocks");
    strobe_reti(); di_strobe = 1; boundary = 1; @(negedge clk); di_strobe = 0; boundary = 0;
    @(negedge clk); drained("R7 di same cycle");
    wr(16'hFF0F, 8'h1F); pc = 16'h0102; sp = 16'h8000;
    strobe_reti(); expect_disp(0); bnd(); drained("R3 lowest wins");
    rd("R5 only bit0 cleared", 16'hFF0F, 8'hFE);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule